// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block is the hazard control for an in-order pipeline. Each cycle it looks at the instruction in decode, at the instruction in execute, and at its own record of the multiply/divide unit. From these it decides whether decode may advance. When decode may not advance, it holds the program counter and the fetch-to-decode register, and it turns the execute-stage entry into a bubble. In that bubble the valid bit and the register write-enable are cleared. The stalled instruction waits in decode.

There are three reasons for a stall:
- A load in execute whose destination is a source of the decode instruction.
- A move-from-HI/LO in decode, or a new multiply or divide, while the autonomous multiply/divide unit is still busy.
- A debug break in decode that has not yet seen the external release input.

The block keeps a countdown scoreboard for the multiply/divide unit. The scoreboard is loaded with a fixed latency each time the block launches a multiply or divide, so the rest of the pipe runs on while the unit works. All stall reasons are merged into one stall. A stall lasts as long as any reason holds and ends in the cycle the last one clears.

Top module: `pipe_interlock`

## Requirements
- R1: After reset the scoreboard is idle. A move-from-HI/LO (op code 1) in decode does not stall, and no launch is flagged for any non-multiply/divide op.
- R2: Decode stalls in the same cycle under the following condition: decode is valid, execute holds a valid load with destination `ex_dst`, and a used decode source (`src_a` with `use_a`, or `src_b` with `use_b`) equals `ex_dst`. A stall raises `freeze_pc`, `freeze_fd` and `bubble_ex` together.
- R3: None of the following causes a load-use stall: destination register 0, a source whose use flag is low, a non-load in execute, or an invalid execute entry.
- R4: A move-from-HI/LO (op 1) stalls while the scoreboard is busy and advances in the cycle the scoreboard becomes idle. Ordinary ops (op 0) never stall on the scoreboard.
- R5: A multiply (op 2) or divide (op 3) in decode that is not stalled raises `md_launch` in that cycle. After that clock edge the scoreboard is busy for exactly MUL_LAT cycles for a multiply, or DIV_LAT cycles for a divide.
- R6: A multiply or divide is not launched while any stall holds decode, including a scoreboard-busy stall. It launches in the first cycle decode is free.
- R7: A break (op 4) stalls for every cycle that `brk_release` is low. It advances in a cycle where `brk_release` is high. `brk_release` has no effect when no break is in decode.
- R8: With `dec_valid` low the block never stalls and never launches, whatever execute and the scoreboard hold.
- R9: A load-use reason and a scoreboard-busy reason in the same cycle produce one continuous stall. That stall ends when the last reason clears, with no gap and no second stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_op | input | 3 | Decode op class: 0 plain, 1 move-from-HI/LO, 2 multiply, 3 divide, 4 break |
| src_a | input | REG_W | First source register of decode instruction |
| use_a | input | 1 | First source is read |
| src_b | input | REG_W | Second source register of decode instruction |
| use_b | input | 1 | Second source is read |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_load | input | 1 | Execute instruction is a load |
| ex_dst | input | REG_W | Destination register of execute instruction |
| brk_release | input | 1 | External release for a held break |
| freeze_pc | output | 1 | Hold the program counter |
| freeze_fd | output | 1 | Hold the fetch-to-decode register |
| bubble_ex | output | 1 | Load a bubble (valid and write-enable cleared) into execute |
| md_launch | output | 1 | Start the multiply/divide unit this cycle |

## Verification
The load-use check and the scoreboard-busy check can both call for a stall in the same cycle. The bench provokes this by launching a multiply and then placing a move-from-HI/LO in decode whose source matches a load sitting in execute. After the first stalled cycle it drops the execute entry, as the bubble would. The bench counts the consecutive frozen cycles and expects exactly MUL_LAT of them, without a break in between. A count of one more, or a gap in the middle, would show that the two reasons were serialized instead of merged.

// File: rtl/interlock_pkg.sv
package interlock_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_HILO  = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_BRK   = 3'd4
  } op_class_e;

  typedef enum int unsigned {
    CAUSE_LOAD = 0,
    CAUSE_HILO = 1,
    CAUSE_MD   = 2,
    CAUSE_BRK  = 3
  } cause_idx_e;

  localparam int unsigned NUM_CAUSE = 4;
endpackage

// File: rtl/load_use_cmp.sv
module load_use_cmp #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic                       dec_valid,
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic [NSRC-1:0]            uses,
  input  logic                       ex_valid,
  input  logic                       ex_load,
  input  logic [REG_W-1:0]           ex_dst,
  output logic                       hazard
);
  logic [NSRC-1:0] hit;
  logic            producer_live;

  // a load writing register zero produces nothing a reader can depend on
  assign producer_live = ex_valid & ex_load & (ex_dst != '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = uses[i] & (srcs[i] == ex_dst);
  end

  assign hazard = dec_valid & producer_live & (|hit);
endmodule

// File: rtl/muldiv_scoreboard.sv
module muldiv_scoreboard #(
  parameter int unsigned MUL_LAT = 4,
  parameter int unsigned DIV_LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_div,
  output logic busy
);
  localparam int unsigned MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT;
  localparam int unsigned CW      = $clog2(MAX_LAT + 1);

  logic [CW-1:0] remain_q;
  logic [CW-1:0] remain_d;
  logic          remain_en;

  assign busy      = (remain_q != '0);
  assign remain_en = launch | busy;

  always_comb begin
    remain_d = remain_q;
    if (launch) begin
      remain_d = launch_div ? CW'(DIV_LAT) : CW'(MUL_LAT);
    end else if (busy) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (remain_en) begin
      remain_q <= remain_d;
    end
  end
endmodule

// File: rtl/stall_arbiter.sv
module stall_arbiter
  import interlock_pkg::*;
(
  input  logic      dec_valid,
  input  op_class_e dec_op,
  input  logic      load_hazard,
  input  logic      md_busy,
  input  logic      brk_release,
  output logic      freeze_pc,
  output logic      freeze_fd,
  output logic      bubble_ex,
  output logic      md_launch,
  output logic      md_is_div
);
  logic [NUM_CAUSE-1:0] cause;
  logic                 is_md;
  logic                 stall;

  assign is_md = (dec_op == OP_MUL) | (dec_op == OP_DIV);

  always_comb begin
    cause             = '0;
    cause[CAUSE_LOAD] = load_hazard;
    cause[CAUSE_HILO] = dec_valid & (dec_op == OP_HILO) & md_busy;
    cause[CAUSE_MD]   = dec_valid & is_md & md_busy;
    cause[CAUSE_BRK]  = dec_valid & (dec_op == OP_BRK) & ~brk_release;
  end

  // every reason merges into one stall; it drops when the last reason drops
  assign stall     = |cause;
  assign freeze_pc = stall;
  assign freeze_fd = stall;
  assign bubble_ex = stall;
  assign md_launch = dec_valid & is_md & ~stall;
  assign md_is_div = (dec_op == OP_DIV);
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import interlock_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned MUL_LAT = 4,
  parameter int unsigned DIV_LAT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_op,
  input  logic [REG_W-1:0] src_a,
  input  logic             use_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             use_b,
  input  logic             ex_valid,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             brk_release,
  output logic             freeze_pc,
  output logic             freeze_fd,
  output logic             bubble_ex,
  output logic             md_launch
);
  localparam int unsigned NSRC = 2;

  logic [1:0]                 rst_pipe_q;
  logic                       rst_sync_n;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            uses;
  logic                       load_hazard;
  logic                       md_busy;
  logic                       md_is_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign srcs = {src_b, src_a};
  assign uses = {use_b, use_a};

  load_use_cmp #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .dec_valid (dec_valid),
    .srcs      (srcs),
    .uses      (uses),
    .ex_valid  (ex_valid),
    .ex_load   (ex_load),
    .ex_dst    (ex_dst),
    .hazard    (load_hazard)
  );

  muldiv_scoreboard #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_sb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .launch     (md_launch),
    .launch_div (md_is_div),
    .busy       (md_busy)
  );

  stall_arbiter u_arb (
    .dec_valid   (dec_valid),
    .dec_op      (op_class_e'(dec_op)),
    .load_hazard (load_hazard),
    .md_busy     (md_busy),
    .brk_release (brk_release),
    .freeze_pc   (freeze_pc),
    .freeze_fd   (freeze_fd),
    .bubble_ex   (bubble_ex),
    .md_launch   (md_launch),
    .md_is_div   (md_is_div)
  );
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             dec_valid,
  input logic [2:0]       dec_op,
  input logic [REG_W-1:0] src_a,
  input logic             use_a,
  input logic [REG_W-1:0] src_b,
  input logic             use_b,
  input logic             ex_valid,
  input logic             ex_load,
  input logic [REG_W-1:0] ex_dst,
  input logic             brk_release,
  input logic             md_busy,
  input logic             freeze_pc,
  input logic             md_launch
);
  // R2
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && ex_valid && ex_load && ex_dst != '0 &&
     ((use_a && src_a == ex_dst) || (use_b && src_b == ex_dst))) |-> freeze_pc);

  // R4
  hilo_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && dec_op == 3'd1 && md_busy) |-> freeze_pc);

  // R7
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && dec_op == 3'd4 && !brk_release) |-> freeze_pc);

  // R8
  empty_decode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dec_valid |-> (!freeze_pc && !md_launch));

  // R6
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    md_launch |-> !md_busy);

  // R5
  launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    md_launch |=> md_busy);

  // R6
  no_launch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    freeze_pc |-> !md_launch);
endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .dec_valid   (dec_valid),
  .dec_op      (dec_op),
  .src_a       (src_a),
  .use_a       (use_a),
  .src_b       (src_b),
  .use_b       (use_b),
  .ex_valid    (ex_valid),
  .ex_load     (ex_load),
  .ex_dst      (ex_dst),
  .brk_release (brk_release),
  .md_busy     (md_busy),
  .freeze_pc   (freeze_pc),
  .md_launch   (md_launch)
);

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned MUL_LAT = 4;
  localparam int unsigned DIV_LAT = 10;

  typedef struct packed {
    logic       v;
    logic [2:0] op;
    logic [4:0] sa;
    logic       ua;
    logic [4:0] sb;
    logic       ub;
    logic       xv;
    logic       xl;
    logic [4:0] xd;
    logic       rel;
    logic       frz;
    logic       lch;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd0, 5'd3, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R1 plain, empty ex
    '{1'b1, 3'd0, 5'd5, 1'b1, 5'd6, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0, 1'b1, 1'b0}, // R2 match on a
    '{1'b1, 3'd0, 5'd5, 1'b1, 5'd9, 1'b1, 1'b1, 1'b1, 5'd9, 1'b0, 1'b1, 1'b0}, // R2 match on b
    '{1'b1, 3'd0, 5'd5, 1'b0, 5'd6, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0}, // R3 unused source
    '{1'b1, 3'd0, 5'd5, 1'b1, 5'd6, 1'b1, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0}, // R3 non-load
    '{1'b1, 3'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0}, // R3 register zero
    '{1'b1, 3'd0, 5'd7, 1'b1, 5'd6, 1'b1, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0}, // R3 invalid ex
    '{1'b0, 3'd0, 5'd7, 1'b1, 5'd6, 1'b1, 1'b1, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0}, // R8 empty decode
    '{1'b1, 3'd1, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R4 hilo idle
    '{1'b1, 3'd4, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0}, // R7 break held
    '{1'b1, 3'd4, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R7 break released
    '{1'b1, 3'd0, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R7 release w/o break
    '{1'b1, 3'd2, 5'd8, 1'b1, 5'd2, 1'b0, 1'b1, 1'b1, 5'd8, 1'b0, 1'b1, 1'b0}  // R6 mul behind load
  };

  logic             clk;
  logic             rst_n;
  logic             dec_valid;
  logic [2:0]       dec_op;
  logic [REG_W-1:0] src_a;
  logic             use_a;
  logic [REG_W-1:0] src_b;
  logic             use_b;
  logic             ex_valid;
  logic             ex_load;
  logic [REG_W-1:0] ex_dst;
  logic             brk_release;
  logic             freeze_pc;
  logic             freeze_fd;
  logic             bubble_ex;
  logic             md_launch;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pipe_interlock #(.REG_W(REG_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .src_a(src_a), .use_a(use_a), .src_b(src_b), .use_b(use_b),
    .ex_valid(ex_valid), .ex_load(ex_load), .ex_dst(ex_dst),
    .brk_release(brk_release), .freeze_pc(freeze_pc), .freeze_fd(freeze_fd),
    .bubble_ex(bubble_ex), .md_launch(md_launch)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_n(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {freeze_pc, freeze_fd, bubble_ex, md_launch};
  endfunction

  function automatic logic [3:0] want(input logic frz, input logic lch);
    return {frz, frz, frz, lch};
  endfunction

  task automatic drive(input logic v, input logic [2:0] op, input logic [4:0] sa, input logic ua,
                       input logic [4:0] sb, input logic ub, input logic xv, input logic xl,
                       input logic [4:0] xd, input logic rel);
    @(negedge clk);
    dec_valid = v; dec_op = op; src_a = sa; use_a = ua; src_b = sb; use_b = ub;
    ex_valid = xv; ex_load = xl; ex_dst = xd; brk_release = rel;
    #1;
  endtask

  task automatic idle_op(input logic [2:0] op);
    drive(1'b1, op, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
  endtask

  // counts consecutive frozen cycles with inputs held, starting with the current cycle
  task automatic count_frozen(output int n);
    n = 0;
    while (freeze_pc && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    dec_valid = 1'b0; dec_op = 3'd0; src_a = '0; use_a = 1'b0; src_b = '0; use_b = 1'b0;
    ex_valid = 1'b0; ex_load = 1'b0; ex_dst = '0; brk_release = 1'b0;
    do_reset();

    // R1 reset state: scoreboard idle, hilo passes
    idle_op(3'd1);
    check("R1 hilo after reset", outs(), want(1'b0, 1'b0));

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].v, TBL[i].op, TBL[i].sa, TBL[i].ua, TBL[i].sb, TBL[i].ub,
            TBL[i].xv, TBL[i].xl, TBL[i].xd, TBL[i].rel);
      check($sformatf("vector %0d", i), outs(), want(TBL[i].frz, TBL[i].lch));
    end

    // R5 multiply launch, then R4 hilo waits exactly MUL_LAT cycles
    idle_op(3'd2);
    check("R5 mul launch", outs(), want(1'b0, 1'b1));
    idle_op(3'd1);
    count_frozen(n);
    check_n("R4 hilo wait after mul", n, MUL_LAT);
    check("R4 hilo advances when idle", outs(), want(1'b0, 1'b0));

    // R5 divide busy length; R4 plain ops pass during busy
    idle_op(3'd3);
    check("R5 div launch", outs(), want(1'b0, 1'b1));
    idle_op(3'd0);
    check("R4 plain op during busy", outs(), want(1'b0, 1'b0));
    idle_op(3'd1);
    count_frozen(n);
    check_n("R5 div busy length", n, DIV_LAT - 1);

    // R6 second mul/div waits for the unit, then launches
    idle_op(3'd2);
    check("R6 first mul launch", outs(), want(1'b0, 1'b1));
    idle_op(3'd3);
    check("R6 div held while busy", outs(), want(1'b1, 1'b0));
    count_frozen(n);
    check_n("R6 div hold length", n, MUL_LAT);
    check("R6 div launches when free", outs(), want(1'b0, 1'b1));
    idle_op(3'd1);
    count_frozen(n);
    check_n("R6 div latency after deferred launch", n, DIV_LAT);

    // R9 load-use and busy at once: one continuous stall of MUL_LAT cycles
    idle_op(3'd2);
    drive(1'b1, 3'd1, 5'd12, 1'b1, 5'd2, 1'b0, 1'b1, 1'b1, 5'd12, 1'b0);
    n = 0;
    if (freeze_pc) begin
      n = 1;
      drive(1'b1, 3'd1, 5'd12, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0); // bubble reached ex
      while (freeze_pc && n < 100) begin
        n++;
        @(negedge clk);
        #1;
      end
    end
    check_n("R9 merged stall length", n, MUL_LAT);

    // R7 break held for several cycles, released by the input
    drive(1'b1, 3'd4, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    repeat (5) begin
      check("R7 break holds", outs(), want(1'b1, 1'b0));
      @(negedge clk);
      #1;
    end
    drive(1'b1, 3'd4, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1);
    check("R7 break released", outs(), want(1'b0, 1'b0));

    // R8 empty decode while busy
    idle_op(3'd3);
    drive(1'b0, 3'd1, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    check("R8 empty decode while busy", outs(), want(1'b0, 1'b0));

    // R1 reset in the middle of a busy window clears the scoreboard
    do_reset();
    idle_op(3'd1);
    check("R1 hilo after mid-busy reset", outs(), want(1'b0, 1'b0));

    done = 1'b1;
    finish_run();
  end
endmodule